// File: doc/BRIEF.md
# Banked Harvard Address Translator

This block turns a 16-bit logical half-word address into a 19-bit physical half-word address by bank switching. Instruction fetches and operand accesses take separate paths. The lower 32K half-words of logical space reach the same physical locations whatever the bank settings are. The upper 32K half-words are relocated into one of sixteen 32K-half-word banks.

Ten 4-bit bank registers hold the bank numbers. Instruction fetches always use the code bank register. Operand accesses use the data bank register unless the effective address was formed from a nonzero base register. In that case one of eight extended data bank registers is used, picked by a 3-bit index equal to the base register number modulo 8.

The translation is combinational. A synchronous write port loads any of the ten registers. A write with an invalid register select changes nothing and produces a one-cycle error pulse.

Top module: `bank_xlate`

## Requirements
- R1: After reset all ten bank registers hold 0, so every upper-half logical address A maps to physical address A[14:0], zero-extended.
- R2: When logical bit 15 is 0, the physical address is the logical address zero-extended to 19 bits, whatever the access type and bank register contents.
- R3: When logical bit 15 is 1 on a fetch (acc_op_i = 0), the physical address is {code bank, A[14:0]}.
- R4: When logical bit 15 is 1 on an operand access (acc_op_i = 1) with base_nz_i = 0, the physical address is {data bank, A[14:0]}.
- R5: When logical bit 15 is 1 on an operand access with base_nz_i = 1, the physical address is {extended register k, A[14:0]}, where k = base_idx_i.
- R6: A write with wr_en_i = 1 loads wr_data_i into the register chosen by wr_sel_i: 0 selects the code bank, 1 the data bank, and 2+k the extended register k (k = 0..7). The new value is first used by translations in the cycle after the write edge.
- R7: A write with wr_sel_i in 10..15 changes no register, and wr_err_o is 1 for exactly the one cycle after that write edge. Otherwise wr_err_o is 0.
- R8: On a fetch, base_nz_i and base_idx_i have no effect on the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bank register write strobe |
| wr_sel_i | input | 4 | Register select: 0 code, 1 data, 2..9 extended 0..7 |
| wr_data_i | input | 4 | Bank number to load |
| wr_err_o | output | 1 | One-cycle pulse after a write with an invalid select |
| acc_op_i | input | 1 | 0 = instruction fetch, 1 = operand access |
| laddr_i | input | 16 | Logical half-word address |
| base_nz_i | input | 1 | Effective address formed from a nonzero base register |
| base_idx_i | input | 3 | Base register number modulo 8 |
| paddr_o | output | 19 | Physical half-word address |

## Verification
The hardest case to reach from the ports is the cycle in which a register write and a translation that depends on that register are both present. Here the output must still show the old bank before the edge and the new bank just after it. The bench drives the write and an upper-half fetch at the same falling edge. It samples the output once before the rising edge and once after it. Invalid selects carry data that is not present in any register, and each one is followed by a full sweep over access types, base flags, indexes and boundary addresses, so a corrupted register would show up.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  localparam int unsigned LA_W   = 16;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned EXT_N  = 8;
  localparam int unsigned NREG   = EXT_N + 2;
  localparam int unsigned SEL_W  = $clog2(NREG);
  localparam int unsigned IDX_W  = $clog2(EXT_N);
  localparam int unsigned PA_W   = LA_W - 1 + BANK_W;

  typedef enum logic {ACC_FETCH = 1'b0, ACC_OPER = 1'b1} acc_e;

  localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_EXT0 = SEL_W'(2);
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_xlate_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SEL_W-1:0]             wr_sel_i,
  input  logic [BANK_W-1:0]            wr_data_i,
  output logic                         wr_err_o,
  output logic [BANK_W-1:0]            code_bank_o,
  output logic [BANK_W-1:0]            data_bank_o,
  output logic [EXT_N-1:0][BANK_W-1:0] ext_bank_o
);
  logic [NREG-1:0][BANK_W-1:0] bank_q;
  logic                        sel_ok;
  logic                        err_q;

  assign sel_ok = wr_sel_i < SEL_W'(NREG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (wr_en_i && sel_ok) begin
      for (int i = 0; i < int'(NREG); i++) begin
        if (wr_sel_i == SEL_W'(i)) bank_q[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_en_i && !sel_ok;
  end

  assign wr_err_o    = err_q;
  assign code_bank_o = bank_q[SEL_CODE];
  assign data_bank_o = bank_q[SEL_DATA];

  for (genvar k = 0; k < int'(EXT_N); k++) begin : g_ext
    assign ext_bank_o[k] = bank_q[int'(SEL_EXT0) + k];
  end

  AST_GOOD_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && sel_ok) |-> bank_q[$past(wr_sel_i)] == $past(wr_data_i)); // R6
  AST_BAD_WR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && !sel_ok) |-> bank_q == $past(bank_q)); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i && (wr_sel_i >= SEL_W'(NREG)))); // R7
endmodule

// File: rtl/bank_pick.sv
module bank_pick
  import bank_xlate_pkg::*;
(
  input  logic                         acc_op_i,
  input  logic                         base_nz_i,
  input  logic [IDX_W-1:0]             base_idx_i,
  input  logic [BANK_W-1:0]            code_bank_i,
  input  logic [BANK_W-1:0]            data_bank_i,
  input  logic [EXT_N-1:0][BANK_W-1:0] ext_bank_i,
  output logic [BANK_W-1:0]            bank_o
);
  always_comb begin
    if (acc_e'(acc_op_i) == ACC_FETCH) bank_o = code_bank_i;
    else if (base_nz_i)                bank_o = ext_bank_i[base_idx_i];
    else                               bank_o = data_bank_i;
  end
endmodule

// File: rtl/addr_relocate.sv
module addr_relocate
  import bank_xlate_pkg::*;
(
  input  logic [LA_W-1:0]   laddr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [PA_W-1:0]   paddr_o
);
  localparam int unsigned OFS_W = LA_W - 1;

  // upper half relocates, lower half is common to all banks
  assign paddr_o = laddr_i[LA_W-1] ? {bank_i, laddr_i[OFS_W-1:0]}
                                   : {{BANK_W{1'b0}}, laddr_i[OFS_W-1:0]};
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BANK_W-1:0] wr_data_i,
  output logic              wr_err_o,
  input  logic              acc_op_i,
  input  logic [LA_W-1:0]   laddr_i,
  input  logic              base_nz_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  output logic [PA_W-1:0]   paddr_o
);
  logic [BANK_W-1:0]            code_bank;
  logic [BANK_W-1:0]            data_bank;
  logic [EXT_N-1:0][BANK_W-1:0] ext_bank;
  logic [BANK_W-1:0]            sel_bank;

  bank_regfile u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .wr_err_o    (wr_err_o),
    .code_bank_o (code_bank),
    .data_bank_o (data_bank),
    .ext_bank_o  (ext_bank)
  );

  bank_pick u_pick (
    .acc_op_i    (acc_op_i),
    .base_nz_i   (base_nz_i),
    .base_idx_i  (base_idx_i),
    .code_bank_i (code_bank),
    .data_bank_i (data_bank),
    .ext_bank_i  (ext_bank),
    .bank_o      (sel_bank)
  );

  addr_relocate u_reloc (
    .laddr_i (laddr_i),
    .bank_i  (sel_bank),
    .paddr_o (paddr_o)
  );

  AST_LOW_HALF_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !laddr_i[LA_W-1] |-> paddr_o[PA_W-1:LA_W-1] == '0); // R2
  AST_FETCH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_op_i && laddr_i[LA_W-1]) |-> paddr_o[PA_W-1 -: BANK_W] == code_bank); // R3
  AST_OPER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_op_i && !base_nz_i && laddr_i[LA_W-1]) |-> paddr_o[PA_W-1 -: BANK_W] == data_bank); // R4
  AST_OPER_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_op_i && base_nz_i && laddr_i[LA_W-1]) |-> paddr_o[PA_W-1 -: BANK_W] == ext_bank[base_idx_i]); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[LA_W-2:0] == laddr_i[LA_W-2:0]); // R2
endmodule

// File: tb/bank_xlate_bench.sv
`timescale 1ns/1ps
module bank_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [3:0]  wr_data = '0;
  logic        wr_err;
  logic        acc_op = 1'b0;
  logic [15:0] laddr = '0;
  logic        base_nz = 1'b0;
  logic [2:0]  base_idx = '0;
  logic [18:0] paddr;

  int errors = 0;
  int checks = 0;
  logic [3:0] model [10];
  logic [15:0] probe [6];

  always #2 clk = ~clk;

  bank_xlate u_bank_xlate (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .wr_err_o(wr_err), .acc_op_i(acc_op),
    .laddr_i(laddr), .base_nz_i(base_nz), .base_idx_i(base_idx), .paddr_o(paddr)
  );

  function automatic logic [18:0] expect_pa(logic op, logic nz, logic [2:0] idx, logic [15:0] a);
    logic [3:0] b;
    if (!op)    b = model[0];
    else if (nz) b = model[2 + int'(idx)];
    else        b = model[1];
    return a[15] ? {b, a[14:0]} : {4'h0, a[14:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] sel, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 10) model[sel] = d;
  endtask

  task automatic sweep(string req);
    for (int op = 0; op < 2; op++)
      for (int nz = 0; nz < 2; nz++)
        for (int ix = 0; ix < 8; ix++)
          for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            acc_op = op[0]; base_nz = nz[0]; base_idx = ix[2:0]; laddr = probe[p];
            #1;
            chk(req, 32'(paddr), 32'(expect_pa(op[0], nz[0], ix[2:0], probe[p])));
          end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    probe[0] = 16'h0000; probe[1] = 16'h7FFF; probe[2] = 16'h8000;
    probe[3] = 16'hFFFF; probe[4] = 16'h1234; probe[5] = 16'hABCD;
    for (int i = 0; i < 10; i++) model[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset err", 32'(wr_err), 0);
    sweep("R1 reset banks");

    // R6: distinct values into every register, then R2..R5, R8
    for (int k = 0; k < 10; k++) wr(4'(k), 4'(k + 3));
    sweep("R2/R3/R4/R5/R8 sweep");

    // R3: walk every bank value on the code bank
    for (int v = 0; v < 16; v++) begin
      wr(4'd0, 4'(v));
      @(negedge clk);
      acc_op = 1'b0; base_nz = 1'b1; base_idx = 3'(v); laddr = 16'hC001;
      #1;
      chk("R3/R8 code walk", 32'(paddr), 32'({4'(v), 15'h4001}));
    end

    // R6: old bank before the write edge, new bank just after it
    @(negedge clk);
    acc_op = 1'b0; laddr = 16'h8005;
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 4'hA;
    #1;
    chk("R6 before edge", 32'(paddr), 32'({model[0], 15'h0005}));
    @(posedge clk);
    #1;
    wr_en = 1'b0; model[0] = 4'hA;
    chk("R6 after edge", 32'(paddr), 32'({4'hA, 15'h0005}));

    // R6: an extended register write reaches only its own index
    wr(4'd7, 4'hE);
    @(negedge clk);
    acc_op = 1'b1; base_nz = 1'b1; base_idx = 3'd5; laddr = 16'hFFFE;
    #1;
    chk("R5/R6 ext5", 32'(paddr), 32'({4'hE, 15'h7FFE}));

    // R7: invalid selects
    for (int s = 10; s < 16; s++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 4'(s); wr_data = 4'hF;
      #1;
      chk("R7 no err before edge", 32'(wr_err), 0);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 err pulse", 32'(wr_err), 1);
      @(negedge clk);
      chk("R7 err ends", 32'(wr_err), 0);
      sweep("R7 regs unchanged");
    end

    // R7: valid write raises no error
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd9; wr_data = 4'h1;
    @(negedge clk);
    wr_en = 1'b0; model[9] = 4'h1;
    chk("R7 valid no err", 32'(wr_err), 0);
    sweep("R5/R6 final sweep");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule